// File: doc/BRIEF.md
# Strided Vector Load from Interleaved Banks

This block fetches a vector of words from a memory that is split into 16 independently timed banks. A single start command supplies a base word address, a signed stride and an element count. An internal address generator then walks the addresses base, base+stride, base+2·stride and so on. For each address it picks the bank from the low four address bits and issues a read to that bank once the bank is free again.

A bank stays occupied for four cycles after each access. A stride that keeps landing on the same bank therefore slows the generator to one element every four cycles. A stride that visits a new bank each time keeps a rate of one element per cycle.

Every read returns after a fixed latency of twelve cycles. Elements reach the output in the order of their index, each tagged with that index. A one-cycle done pulse follows the final element. The memory contents come from an array held inside the block. Word `a` holds `(a * 0x9E3779B1) ^ 0xC3A50000`, truncated to 32 bits.

Top module: `vec_bank_reader`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy`, `done` and `rd_valid` are all low.
- R2: A `start` is accepted only while `busy` is low and `vlen` lies in 1..64. A `start` with `vlen` of 0 or above 64 has no effect, and so does a `start` given while `busy` is high. `busy` rises in the cycle after an accepted start.
- R3: Element i is read from word address (base + i·stride) mod 1024, with `stride` taken as a 10-bit two's-complement value.
- R4: Address bits [3:0] select one of 16 banks, and at most one read is issued per cycle. The first read may issue in the cycle right after the start is accepted.
- R5: A bank that accepts a read in cycle t accepts no other read before cycle t+4. With a stride of 16 or 0, elements therefore arrive one every 4 cycles.
- R6: Reads issue strictly in element order. When the next element's bank is occupied, the generator waits for it and no later element is issued first. With a stride of 1, one element arrives per cycle.
- R7: The data for an element issued in cycle c appears on `rd_data`, with `rd_valid` high and `rd_idx` set to the element index, in cycle c+12.
- R8: `busy` stays high until the cycle in which the last element is delivered, inclusive. In the next cycle `busy` is low and `done` is high for exactly that one cycle.
- R9: `rd_valid` is high only while `busy` is high, and each delivery carries the index one above the previous delivery, starting at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start command strobe |
| base | input | 10 | Base word address |
| stride | input | 10 | Signed element stride in words |
| vlen | input | 7 | Element count, 1..64 |
| busy | output | 1 | A vector load is in progress |
| done | output | 1 | One-cycle pulse after the last element |
| rd_valid | output | 1 | Returned element valid |
| rd_idx | output | 6 | Index of the returned element |
| rd_data | output | 32 | Returned element data |

## Verification
The bench keeps the default parameters: a 1024-word space, 16 banks, a 4-cycle bank occupancy, a 12-cycle latency and 64 as the longest vector. With these values, a full 64-element run fits inside the space. A negative stride starting from a low base wraps below address zero, and the stride values 16, 8 and 0 reach every amount of bank conflict, from the worst case to the alternating case. The greedy issue schedule in the bench then pins down each delivery cycle exactly.

// File: rtl/vec_bank_reader.sv
module vec_bank_reader #(
  parameter int AW        = 10,
  parameter int DW        = 32,
  parameter int BANK_BITS = 4,
  parameter int BANK_BUSY = 4,
  parameter int LATENCY   = 12,
  parameter int MAXLEN    = 64,
  localparam int LENW     = $clog2(MAXLEN + 1),
  localparam int IDXW     = $clog2(MAXLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   base,
  input  logic [AW-1:0]   stride,
  input  logic [LENW-1:0] vlen,
  output logic            busy,
  output logic            done,
  output logic            rd_valid,
  output logic [IDXW-1:0] rd_idx,
  output logic [DW-1:0]   rd_data
);
  localparam int NBANK = 1 << BANK_BITS;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(BANK_BUSY + 1);
  localparam int HD    = BANK_BUSY - 1;

  logic [DW-1:0] mem [DEPTH];
  initial begin
    for (int a = 0; a < DEPTH; a++)
      mem[a] = DW'(32'(a) * 32'h9E3779B1) ^ DW'(32'hC3A50000);
  end

  logic            run_q, done_q;
  logic [AW-1:0]   addr_q, stride_q;
  logic [LENW-1:0] len_q, iss_cnt;
  logic [CW-1:0]   bcnt [NBANK];
  logic            pv [LATENCY];
  logic [IDXW-1:0] pi [LATENCY];
  logic [DW-1:0]   pd [LATENCY];

  wire [BANK_BITS-1:0] bank = addr_q[BANK_BITS-1:0];
  wire accept = start && !run_q && (vlen != '0) && (vlen <= LENW'(MAXLEN));
  wire issue  = run_q && (iss_cnt < len_q) && (bcnt[bank] == '0);
  wire last   = pv[LATENCY-1] && (LENW'(pi[LATENCY-1]) == len_q - 1'b1);

  assign busy     = run_q;
  assign done     = done_q;
  assign rd_valid = pv[LATENCY-1];
  assign rd_idx   = pi[LATENCY-1];
  assign rd_data  = pd[LATENCY-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      done_q   <= 1'b0;
      addr_q   <= '0;
      stride_q <= '0;
      len_q    <= '0;
      iss_cnt  <= '0;
      for (int b = 0; b < NBANK; b++) bcnt[b] <= '0;
      for (int k = 0; k < LATENCY; k++) pv[k] <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        run_q    <= 1'b1;
        addr_q   <= base;
        stride_q <= stride;
        len_q    <= vlen;
        iss_cnt  <= '0;
      end else if (run_q && last) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
      if (issue) begin
        addr_q  <= addr_q + stride_q;
        iss_cnt <= iss_cnt + 1'b1;
      end
      for (int b = 0; b < NBANK; b++) begin
        if (issue && bank == BANK_BITS'(b)) bcnt[b] <= CW'(BANK_BUSY - 1);
        else if (bcnt[b] != '0)             bcnt[b] <= bcnt[b] - 1'b1;
      end
      pv[0] <= issue;
      for (int k = 1; k < LATENCY; k++) pv[k] <= pv[k-1];
    end
  end

  always_ff @(posedge clk) begin
    pi[0] <= iss_cnt[IDXW-1:0];
    pd[0] <= mem[addr_q];
    for (int k = 1; k < LATENCY; k++) begin
      pi[k] <= pi[k-1];
      pd[k] <= pd[k-1];
    end
  end

  logic                 hv [HD];
  logic [BANK_BITS-1:0] hb [HD];
  logic                 clash;
  logic [IDXW-1:0]      prev_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < HD; k++) begin
        hv[k] <= 1'b0;
        hb[k] <= '0;
      end
      prev_idx <= '0;
    end else begin
      hv[0] <= issue;
      hb[0] <= bank;
      for (int k = 1; k < HD; k++) begin
        hv[k] <= hv[k-1];
        hb[k] <= hb[k-1];
      end
      if (rd_valid) prev_idx <= rd_idx;
    end
  end

  always_comb begin
    clash = 1'b0;
    for (int k = 0; k < HD; k++)
      if (hv[k] && hb[k] == bank) clash = 1'b1;
  end

  a_r5_bank_rest: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !clash);
  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(len_q));
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(rd_valid) && !busy));
  a_r9_valid_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);
  a_r9_index_order: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_idx != '0) |-> (rd_idx == prev_idx + 1'b1));
endmodule

// File: tb/vec_bank_reader_tb.sv
module vec_bank_reader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [9:0] base = '0, stride = '0;
  logic [6:0] vlen = '0;
  logic busy, done, rd_valid;
  logic [5:0] rd_idx;
  logic [31:0] rd_data;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vec_bank_reader u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride),
    .vlen(vlen), .busy(busy), .done(done), .rd_valid(rd_valid),
    .rd_idx(rd_idx), .rd_data(rd_data));

  function automatic logic [31:0] word_at(input int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'hC3A50000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic idle_try(input int n, input string tag);
    @(negedge clk);
    start = 1'b1; base = 10'd7; stride = 10'd1; vlen = 7'(n);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      start = 1'b0;
      chk(!busy, {tag, " busy"}, 64'(busy), 0);
      chk(!rd_valid && !done, {tag, " valid/done"}, 64'({rd_valid, done}), 0);
    end
  endtask

  task automatic run_vec(input int b, input int s, input int n, input int inj,
                         input string tag);
    int ic[64];
    int lastb[16];
    int fin, t, a, e;
    for (int k = 0; k < 16; k++) lastb[k] = -100;
    for (int i = 0; i < n; i++) begin
      a = (b + i * s) & 1023;
      t = (i == 0) ? 0 : ic[i-1] + 1;
      if (lastb[a & 15] + 4 > t) t = lastb[a & 15] + 4;
      ic[i] = t;
      lastb[a & 15] = t;
    end
    fin = ic[n-1] + 12;
    @(negedge clk);
    start = 1'b1; base = 10'(b); stride = 10'(s); vlen = 7'(n);
    for (int k = 0; k <= fin + 2; k++) begin
      @(negedge clk);
      start = (k == inj);
      if (k == inj) begin base = 10'd3; stride = 10'd2; vlen = 7'd5; end
      e = -1;
      for (int i = 0; i < n; i++) if (ic[i] + 12 == k) e = i;
      chk(busy == (k <= fin), "R2 R8 busy", 64'(busy), 64'(k <= fin));
      chk(done == (k == fin + 1), "R8 done", 64'(done), 64'(k == fin + 1));
      chk(rd_valid == (e >= 0), {tag, " R7 R9 valid"}, 64'(rd_valid), 64'(e >= 0));
      if (e >= 0 && rd_valid) begin
        chk(rd_idx == 6'(e), "R6 R9 index", 64'(rd_idx), 64'(e));
        a = (b + e * s) & 1023;
        chk(rd_data == word_at(a), "R3 R4 data", 64'(rd_data), 64'(word_at(a)));
      end
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_valid, "R1 in reset", 64'({busy, done, rd_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !rd_valid, "R1 after reset", 64'({busy, done, rd_valid}), 0);
    idle_try(0, "R2 zero length");
    idle_try(65, "R2 oversize length");
    run_vec(100, 1, 64, -1, "R6 unit stride");
    run_vec(4, 16, 8, -1, "R5 same bank");
    run_vec(0, 0, 5, -1, "R5 zero stride");
    run_vec(12, 8, 10, -1, "R5 two banks");
    run_vec(5, -1, 20, -1, "R3 negative wrap");
    run_vec(1000, 3, 1, -1, "R4 single");
    run_vec(33, 17, 33, 6, "R2 start while busy");
    run_vec(9, -16, 6, -1, "R3 R5 negative same bank");
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end
endmodule